// File: doc/BRIEF.md
# Sixteen-Bit Word Serializer with Elastic Store

This block is the transmit side of a word-to-bit converter. A 16-bit word arrives on every rising edge of a parallel input clock and is captured into a holding register. It then passes through a small elastic store into an internal word-rate domain. There it is loaded into a shift register and sent out one bit per cycle of a fast bit clock. The most significant bit goes out first.

The word rate is derived inside the block by dividing the bit clock by 16. A word-rate clock output is provided. It marks the first bit of each word, and it stays low while reset is held. The phase between the input clock and the internal word rate is arbitrary. A rising edge on the phase-initialization input re-centres the read pointer of the store against the write pointer. A sticky flag reports when the two pointers meet.

Top module: `ser16_estore`

## Requirements
- R1: Each word is sent bit 15 first and bit 0 last, with one bit per bit-clock cycle. Bit 15 is on `sdata_o` in the cycle in which `wclk_o` rises.
- R2: `wclk_o` rises once every 16 bit-clock cycles. It is high for the first 8 bits of a word and low for the last 8.
- R3: While the input clock runs at exactly one sixteenth of the bit-clock rate, every captured word reaches the serial output once, in capture order, with no word skipped or repeated.
- R4: While `rst_n_i` is low, `sdata_o`, `svld_o`, `wclk_o` and `slip_o` are all 0, and `wclk_o` does not toggle.
- R5: After reset is released, `svld_o` goes high at the 16th rising bit-clock edge and stays high until the next reset.
- R6: A read from the store when no unread word is visible (underflow, for example when the input clock stalls) sets `slip_o`. The flag stays set after the input clock resumes.
- R7: A read when the writer is more than the store depth (8 words) ahead (overflow, for example when the input clock runs fast) sets `slip_o`.
- R8: A rising edge of `phinit_i` takes effect at the next word boundary. It places the read pointer half the depth (4 words) behind the synchronized write pointer and clears `slip_o`. From then on, words are again delivered in order. The time from a word being presented at the input to its first serial bit is between 3 and 7 word periods.
- R9: Holding `phinit_i` high causes only one realignment. A slip that occurs while the input stays high remains flagged.
- R10: Asserting `rst_n_i` clears `slip_o` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk_i | input | 1 | Bit-rate clock |
| pclk_i | input | 1 | Parallel input clock, one word per rising edge |
| rst_n_i | input | 1 | Active-low asynchronous reset for both domains |
| pdata_i | input | 16 | Parallel word, bit 15 transmitted first |
| phinit_i | input | 1 | Phase initialization; the rising edge recentres the store |
| sdata_o | output | 1 | Serial data |
| svld_o | output | 1 | High once the first word has been loaded after reset |
| wclk_o | output | 1 | Word-rate clock; rises with bit 15 of each word |
| slip_o | output | 1 | Sticky flag for a store underflow or overflow |

## Verification
A word captured on a rising edge of `pclk_i` is written into the store one input-clock period later. It becomes visible to the reader two or three bit-clock cycles after that. Its bit 15 appears at a word boundary a few word periods later, so the bench checks a delay window rather than an exact cycle. The bench samples on falling bit-clock edges and rebuilds each word from the 16 samples that start at a rise of `wclk_o`. `svld_o` is expected exactly 16 edges after reset release. A realignment lands at the first word boundary after a three-flop synchronizer, so the flag checks wait two full word periods before sampling.

// File: rtl/ser16_estore.sv
module ser16_estore #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         fclk_i,
  input  logic         pclk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] pdata_i,
  input  logic         phinit_i,
  output logic         sdata_o,
  output logic         svld_o,
  output logic         wclk_o,
  output logic         slip_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int CW   = $clog2(W);
  localparam int HALF = DEPTH / 2;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // input-clock domain
  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  hold_q;
  logic [PW-1:0] wptr_q, wgray_q;

  always_ff @(posedge pclk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      hold_q  <= '0;
      wptr_q  <= '0;
      wgray_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      hold_q               <= pdata_i;
      mem[wptr_q[AW-1:0]]  <= hold_q;
      wptr_q               <= wptr_q + 1'b1;
      wgray_q              <= b2g(wptr_q + 1'b1);
    end
  end

  // bit-clock domain
  logic [PW-1:0] wg_s1, wg_s2, rptr_q;
  logic [2:0]    ph_s;
  logic          pend_q, vld_q, slip_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sreg_q;

  wire [PW-1:0] wsync  = g2b(wg_s2);
  wire          tick   = (cnt_q == CW'(W - 1));
  wire          ph_rise = ph_s[1] & ~ph_s[2];
  wire          align  = tick & (pend_q | ph_rise);
  wire [PW-1:0] rd_ptr = align ? (wsync - PW'(HALF)) : rptr_q;
  wire [PW-1:0] occ    = wsync - rptr_q;
  wire          bad    = tick & ~align & ((occ == '0) | (occ > PW'(DEPTH)));

  always_ff @(posedge fclk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wg_s1  <= '0;
      wg_s2  <= '0;
      ph_s   <= '0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      rptr_q <= PW'(DEPTH + HALF);
      sreg_q <= '0;
      vld_q  <= 1'b0;
      slip_q <= 1'b0;
    end else begin
      wg_s1 <= wgray_q;
      wg_s2 <= wg_s1;
      ph_s  <= {ph_s[1:0], phinit_i};
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (align)        pend_q <= 1'b0;
      else if (ph_rise) pend_q <= 1'b1;
      if (tick) begin
        sreg_q <= mem[rd_ptr[AW-1:0]];
        rptr_q <= rd_ptr + 1'b1;
        vld_q  <= 1'b1;
      end else begin
        sreg_q <= {sreg_q[W-2:0], 1'b0};
      end
      if (align)    slip_q <= 1'b0;
      else if (bad) slip_q <= 1'b1;
    end
  end

  assign sdata_o = sreg_q[W-1];
  assign svld_o  = vld_q;
  assign wclk_o  = vld_q & ~cnt_q[CW-1];
  assign slip_o  = slip_q;

  a_r1_msb_shift: assert property (@(posedge fclk_i) disable iff (!rst_n_i)
    (vld_q && !tick) |=> sreg_q == {$past(sreg_q[W-2:0]), 1'b0});
  a_r2_boundary: assert property (@(posedge fclk_i) disable iff (!rst_n_i)
    $rose(wclk_o) |-> $past(cnt_q) == CW'(W - 1));
  a_r3_gray_step: assert property (@(posedge fclk_i) disable iff (!rst_n_i)
    $countones(wg_s1 ^ $past(wg_s1)) <= 1);
  a_r5_vld_hold: assert property (@(posedge fclk_i) disable iff (!rst_n_i)
    vld_q |=> vld_q);
  a_r6_sticky: assert property (@(posedge fclk_i) disable iff (!rst_n_i)
    (slip_q && !align) |=> slip_q);
  a_r8_clear: assert property (@(posedge fclk_i) disable iff (!rst_n_i)
    align |=> !slip_q);
  a_r9_once: assert property (@(posedge fclk_i) disable iff (!rst_n_i)
    align |=> !pend_q);
endmodule

// File: tb/ser16_estore_tb.sv
`timescale 1ns/1ps
module ser16_estore_tb;
  logic        fclk = 0, pclk = 0, rst_n = 0, phinit = 0;
  logic [15:0] pdata = '0;
  logic        sdata, svld, wclk, slip;

  ser16_estore u_dut (
    .fclk_i(fclk), .pclk_i(pclk), .rst_n_i(rst_n), .pdata_i(pdata),
    .phinit_i(phinit), .sdata_o(sdata), .svld_o(svld), .wclk_o(wclk), .slip_o(slip)
  );

  always #5 fclk = ~fclk;

  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{16'h8000, 16'h0001, 16'hFFFF, 16'hAAAA, 16'h5555,
                                       16'h1234, 16'hF00F, 16'h0FF0, 16'hC3A5, 16'h7FFE};

  int  checks = 0, fails = 0, words_ok = 0, tog = 0;
  int  half = 80, sn = 0, exp_n = 0, nb = 0, since = 0;
  bit  run = 0, chk_en = 0, lat_en = 0, locked = 0, done = 0, prev_w = 0, seen_rise = 0;
  logic [15:0] acc;
  time sent_t [256];

  function automatic logic [15:0] f(input int n);
    logic [7:0] b = n[7:0];
    if (n < NV) return VEC[n];
    return {8'h5A ^ b, b};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_rng(input string req, input longint v, input longint lo, input longint hi);
    checks++;
    if (v < lo || v > hi) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, v, lo, hi);
    end
  endtask

  initial begin
    forever begin
      if (run) begin
        if (sn == 0) begin pdata = f(0); sent_t[0] = $time; sn = 1; end
        pclk = 1; #(half);
        pclk = 0; pdata = f(sn); sent_t[sn % 256] = $time; sn++; #(half);
      end else #10;
    end
  end

  task automatic take_word(input logic [15:0] w);
    if (!chk_en) return;
    if (!locked) begin
      if (w == VEC[0] && exp_n == 0) begin locked = 1; exp_n = 1; end
      else if (w[15:8] == (8'h5A ^ w[7:0]) && w[7:0] >= NV) begin locked = 1; exp_n = w[7:0] + 1; end
      return;
    end
    if (exp_n < NV) chk("R1 table word MSB first", w, VEC[exp_n]);
    else            chk("R3 in-order word", w, f(exp_n));
    if (w == f(exp_n)) words_ok++;
    if (lat_en) chk_rng("R8 input-to-serial delay ns", longint'($time) - 155 - longint'(sent_t[exp_n % 256]), 480, 1120);
    exp_n++;
  endtask

  always @(negedge fclk) begin
    if (!rst_n) begin
      if (wclk !== prev_w) tog++;
      prev_w = wclk; nb = 0; seen_rise = 0;
    end else begin
      since++;
      if (wclk && !prev_w) begin
        if (seen_rise) chk("R2 word period", since, 16);
        seen_rise = 1; since = 0; acc = {15'b0, sdata}; nb = 1;
      end else if (nb > 0) begin
        if (nb == 8) chk("R2 low half", wclk, 0);
        acc = {acc[14:0], sdata}; nb++;
        if (nb == 16) begin take_word(acc); nb = 0; end
      end
      prev_w = wclk;
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (20) @(negedge fclk);
    chk("R4 sdata in reset", sdata, 0);
    chk("R4 svld in reset", svld, 0);
    chk("R4 wclk in reset", wclk, 0);
    chk("R4 slip in reset", slip, 0);
    chk("R4 wclk toggles in reset", tog, 0);
    rst_n = 1;
    repeat (15) @(negedge fclk);
    chk("R5 svld before 16th edge", svld, 0);
    @(negedge fclk);
    chk("R5 svld at 16th edge", svld, 1);
    chk("R2 wclk rises with first load", wclk, 1);
    chk("R1 first bit of reset-cleared word", sdata, 0);
    run = 1; chk_en = 1; lat_en = 1; words_ok = 0;
    repeat (40 * 16) @(negedge fclk);
    chk("R3 words delivered after reset", words_ok >= 28, 1);
    chk("R5 svld stays high", svld, 1);
    chk("R6 no slip at matched rate", slip, 0);

    chk_en = 0; locked = 0; run = 0;
    repeat (160) @(negedge fclk);
    chk("R6 underflow flagged", slip, 1);
    run = 1;
    repeat (96) @(negedge fclk);
    chk("R6 flag sticky after resume", slip, 1);
    phinit = 1; repeat (5) @(negedge fclk); phinit = 0;
    repeat (32) @(negedge fclk);
    chk("R8 realign clears flag", slip, 0);
    chk_en = 1; words_ok = 0;
    repeat (20 * 16) @(negedge fclk);
    chk("R8 in-order after realign", words_ok >= 14, 1);

    chk_en = 0; locked = 0; half = 40;
    repeat (192) @(negedge fclk);
    half = 80;
    repeat (32) @(negedge fclk);
    chk("R7 overflow flagged", slip, 1);
    phinit = 1;
    repeat (40) @(negedge fclk);
    chk("R9 first edge realigns", slip, 0);
    run = 0; repeat (160) @(negedge fclk); run = 1;
    repeat (48) @(negedge fclk);
    chk("R9 held level does not realign again", slip, 1);
    phinit = 0; repeat (8) @(negedge fclk); phinit = 1;
    repeat (40) @(negedge fclk);
    chk("R8 new edge clears flag", slip, 0);
    chk_en = 1; words_ok = 0;
    repeat (20 * 16) @(negedge fclk);
    phinit = 0;
    chk("R8 in-order after second realign", words_ok >= 14, 1);

    chk_en = 0; run = 0;
    repeat (160) @(negedge fclk);
    chk("R10 slip set before reset", slip, 1);
    rst_n = 0; #1;
    chk("R10 reset clears slip", slip, 0);
    chk("R4 svld cleared by reset", svld, 0);
    chk("R4 wclk low in reset", wclk, 0);
    @(negedge fclk); #1 tog = 0;
    repeat (40) @(negedge fclk);
    chk("R4 wclk static in reset", tog, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule